// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block produces the timing pulses a UART core needs, using only the crystal clock. The first stage is a phase accumulator. Every crystal cycle it adds a programmable multiplier, and each time the sum reaches a programmable divider it subtracts the divider and raises a one-cycle enable. The enables form an effective UART clock at crystal × MUL / DIV.

A prescale counter divides those enables into a one-cycle sample pulse, used as the oversampling strobe. A divisor-latch counter then divides the sample pulses into the bit-rate tick. The result is bit rate = crystal × MUL / DIV / PS / DL. For example, a 38.4 MHz crystal with MUL = 96 and DIV = 125 gives a 29.4912 MHz effective clock. With PS = 16 and DL = 16 that gives 115200 baud.

The three rate registers (multiplier, divider, prescaler) are 32 bits wide and sit on a simple write/read port. Each register index is scaled by 2^REG_SHIFT to form its byte address. The divisor-latch value comes in as an input from the surrounding UART register set.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the prescaler reads 16 at byte address 0x30, the multiplier reads 96 at 0x34 and the divider reads 125 at 0x38 (each offset shifted left by REG_SHIFT). Any other address reads 0, and all three pulse outputs are low while reset is held.
- R2: A write to a mapped address replaces all 32 bits of that register, visible on `rdata` from the next cycle. A write to an unmapped address changes no register.
- R3: With 0 < MUL ≤ DIV, `frac_en` pulses on average MUL times per DIV crystal cycles. Over any steady window its count is within one of cycles × MUL / DIV.
- R4: `samp_en` pulses once per PS `frac_en` pulses. Over a steady window its count is within one of cycles × MUL / (DIV × PS).
- R5: `baud_tick` pulses once per DL `samp_en` pulses. Over a steady window its count is within one of cycles × MUL / (DIV × PS × DL).
- R6: While DIV = 0 or MUL > DIV, none of the three outputs pulses.
- R7: While PS = 0 or DL = 0, none of the three outputs pulses.
- R8: A write to any rate register restarts the generator from phase zero. All three outputs are low in the cycle after the write. With MUL = DIV = PS = 1 and DL = 4, the first `baud_tick` comes 6 cycles after the write edge and then every 4 cycles.
- R9: A change of `dl_value` restarts the generator in the same way. With MUL = DIV = PS = 1 and a new DL of 5, the first tick comes 7 cycles after the change and the next one 5 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| dl_value | input | DL_W | Divisor-latch value |
| frac_en | output | 1 | Effective UART clock enable |
| samp_en | output | 1 | Oversampling pulse after the prescaler |
| baud_tick | output | 1 | Bit-rate tick after the divisor latch |

## Verification
Each stage adds one register, so the outputs come due at fixed offsets from a restart edge:
- `frac_en` one cycle after the edge;
- `samp_en` one cycle after the `frac_en` that completes its count;
- `baud_tick` one cycle after the completing `samp_en`.

Register writes appear on `rdata` in the following cycle. The bench drives at the falling edge and samples at the next falling edge. It counts restart latency in whole cycles from the write edge, and expects the 6- and 7-cycle first-tick figures derived from that chain. Rate checks wait 64 settling cycles after the last restart and then count pulses over a fixed window. This keeps the three-stage pipeline fill out of the ±1 tolerance.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_REGS = 3;

  // Register indices into the rate register array
  localparam int IDX_PS  = 0;
  localparam int IDX_MUL = 1;
  localparam int IDX_DIV = 2;

  // Unscaled register offsets (byte address = offset << REG_SHIFT)
  localparam logic [7:0] OFF_PS  = 8'h30;
  localparam logic [7:0] OFF_MUL = 8'h34;
  localparam logic [7:0] OFF_DIV = 8'h38;

  typedef logic [DATA_W-1:0] word_t;

  function automatic logic [7:0] reg_offset(input int idx);
    case (idx)
      IDX_PS:  return OFF_PS;
      IDX_MUL: return OFF_MUL;
      default: return OFF_DIV;
    endcase
  endfunction
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int REG_SHIFT = 0,
  parameter int ADDR_W    = 6 + REG_SHIFT,
  parameter int RST_PS    = 16,
  parameter int RST_MUL   = 96,
  parameter int RST_DIV   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  output word_t             rdata,
  output word_t             ps_q,
  output word_t             mul_q,
  output word_t             div_q,
  output logic              wr_hit
);
  word_t                 reg_q   [NUM_REGS];
  logic [NUM_REGS-1:0]   sel;

  function automatic word_t reset_value(input int idx);
    case (idx)
      IDX_PS:  return word_t'(RST_PS);
      IDX_MUL: return word_t'(RST_MUL);
      default: return word_t'(RST_DIV);
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] BYTE_ADDR =
      ADDR_W'({24'd0, reg_offset(g)} << REG_SHIFT);
    word_t reg_d;
    logic  reg_we;

    assign sel[g] = (addr == BYTE_ADDR);

    always_comb begin
      reg_we = wr_en & sel[g];
      reg_d  = reg_we ? wdata : reg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= reset_value(g);
      else if (reg_we) reg_q[g] <= reg_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rdata = reg_q[i];
    end
  end

  assign wr_hit = wr_en & (|sel);
  assign ps_q   = reg_q[IDX_PS];
  assign mul_q  = reg_q[IDX_MUL];
  assign div_q  = reg_q[IDX_DIV];
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] step,
  input  logic [W-1:0] modulus,
  output logic         en
);
  logic [W-1:0] phase_q, phase_d;
  logic         en_d;
  logic [W:0]   sum;
  logic [W:0]   wrapped;
  logic         reach;

  always_comb begin
    sum     = {1'b0, phase_q} + {1'b0, step};
    reach   = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    if (clr) begin
      phase_d = '0;
      en_d    = 1'b0;
    end else if (reach) begin
      phase_d = wrapped[W-1:0];
      en_d    = 1'b1;
    end else begin
      phase_d = sum[W-1:0];
      en_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      en      <= 1'b0;
    end else begin
      phase_q <= phase_d;
      en      <= en_d;
    end
  end
endmodule

// File: rtl/fbg_pulse_div.sv
module fbg_pulse_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         pulse_in,
  input  logic [W-1:0] limit,
  output logic         pulse_out
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cnt_inc;
  logic         out_d;
  logic         last;

  always_comb begin
    cnt_inc = cnt_q + W'(1);
    last    = (cnt_inc == limit);
    cnt_d   = cnt_q;
    out_d   = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (pulse_in) begin
      if (last) begin
        cnt_d = '0;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pulse_out <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      pulse_out <= out_d;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int REG_SHIFT = 0,
  parameter int ADDR_W    = 6 + REG_SHIFT,
  parameter int DL_W      = 16,
  parameter int RST_PS    = 16,
  parameter int RST_MUL   = 96,
  parameter int RST_DIV   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [DL_W-1:0]   dl_value,
  output logic              frac_en,
  output logic              samp_en,
  output logic              baud_tick
);
  word_t           ps_q, mul_q, div_q;
  logic            wr_hit;
  logic [DL_W-1:0] dl_q;
  logic            dl_change;
  logic            rate_bad;
  logic            restart;

  fbg_regs #(
    .REG_SHIFT (REG_SHIFT),
    .ADDR_W    (ADDR_W),
    .RST_PS    (RST_PS),
    .RST_MUL   (RST_MUL),
    .RST_DIV   (RST_DIV)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .ps_q   (ps_q),
    .mul_q  (mul_q),
    .div_q  (div_q),
    .wr_hit (wr_hit)
  );

  // Track the divisor latch so a change restarts the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_q <= '0;
    else        dl_q <= dl_value;
  end

  always_comb begin
    dl_change = (dl_q != dl_value);
    rate_bad  = (div_q == '0) | (mul_q > div_q) | (ps_q == '0) | (dl_value == '0);
    restart   = wr_hit | dl_change | rate_bad;
  end

  fbg_frac_acc #(.W(DATA_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .step    (mul_q),
    .modulus (div_q),
    .en      (frac_en)
  );

  fbg_pulse_div #(.W(DATA_W)) u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart),
    .pulse_in  (frac_en),
    .limit     (ps_q),
    .pulse_out (samp_en)
  );

  fbg_pulse_div #(.W(DL_W)) u_divlatch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart),
    .pulse_in  (samp_en),
    .limit     (dl_value),
    .pulse_out (baud_tick)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int DL_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_hit,
  input logic [31:0]     mul_q,
  input logic [31:0]     div_q,
  input logic [31:0]     ps_q,
  input logic [DL_W-1:0] dl_value,
  input logic [DL_W-1:0] dl_q,
  input logic            frac_en,
  input logic            samp_en,
  input logic            baud_tick
);
  logic bad_ratio;
  logic zero_div;
  assign bad_ratio = (div_q == 32'd0) || (mul_q > div_q);
  assign zero_div  = (ps_q == 32'd0) || (dl_value == '0);

  p_quiet_bad_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_ratio) |-> (!frac_en && !samp_en && !baud_tick));

  p_quiet_zero_divisor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(zero_div) |-> (!frac_en && !samp_en && !baud_tick));

  p_samp_follows_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |-> $past(frac_en));

  p_tick_follows_samp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(samp_en));

  p_write_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hit) |-> (!frac_en && !samp_en && !baud_tick));

  p_dl_change_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dl_q != dl_value) |-> (!frac_en && !samp_en && !baud_tick));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DL_W(DL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .mul_q     (mul_q),
  .div_q     (div_q),
  .ps_q      (ps_q),
  .dl_value  (dl_value),
  .dl_q      (dl_q),
  .frac_en   (frac_en),
  .samp_en   (samp_en),
  .baud_tick (baud_tick)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DL_W = 16;
  localparam logic [ADDR_W-1:0] A_PS  = 6'h30;
  localparam logic [ADDR_W-1:0] A_MUL = 6'h34;
  localparam logic [ADDR_W-1:0] A_DIV = 6'h38;
  localparam logic [ADDR_W-1:0] A_NONE = 6'h3C;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic [DL_W-1:0]   dl_value;
  logic              frac_en, samp_en, baud_tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dl_value(dl_value), .frac_en(frac_en),
    .samp_en(samp_en), .baud_tick(baud_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act > exp + 1 || act < exp - 1) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (+/-1)", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk_eq("R1 frac_en in reset", frac_en, 0);
    chk_eq("R1 samp_en in reset", samp_en, 0);
    chk_eq("R1 baud_tick in reset", baud_tick, 0);
    @(negedge clk); rst_n = 1'b1;
    reg_read(A_PS, v);   chk_eq("R1 PS reset", v, 16);
    reg_read(A_MUL, v);  chk_eq("R1 MUL reset", v, 96);
    reg_read(A_DIV, v);  chk_eq("R1 DIV reset", v, 125);
    reg_read(A_NONE, v); chk_eq("R1 unmapped read", v, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    reg_write(A_PS, 32'hA5A5_0003);
    reg_read(A_PS, v);   chk_eq("R2 PS full write", v, 32'hA5A5_0003);
    reg_write(A_NONE, 32'hFFFF_FFFF);
    reg_write(6'h00, 32'h1234_5678);
    reg_read(A_PS, v);   chk_eq("R2 PS after unmapped", v, 32'hA5A5_0003);
    reg_read(A_MUL, v);  chk_eq("R2 MUL after unmapped", v, 96);
    reg_read(A_DIV, v);  chk_eq("R2 DIV after unmapped", v, 125);
    reg_read(A_NONE, v); chk_eq("R2 unmapped stays 0", v, 0);
    reg_write(A_PS, 32'd16);
  endtask

  task automatic t_rate(input int m, input int d, input int p, input int l, input int win);
    longint cf, cs, ct, ef, es, et;
    dl_value = DL_W'(l);
    reg_write(A_MUL, m);
    reg_write(A_DIV, d);
    reg_write(A_PS, p);
    repeat (64) @(negedge clk);
    cf = 0; cs = 0; ct = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      cf += frac_en; cs += samp_en; ct += baud_tick;
    end
    ef = longint'(win) * m / d;
    es = ef / p;
    et = es / l;
    chk_near($sformatf("R3 frac rate %0d/%0d", m, d), cf, ef);
    chk_near($sformatf("R4 samp rate ps=%0d", p), cs, es);
    chk_near($sformatf("R5 tick rate dl=%0d", l), ct, et);
  endtask

  task automatic count_quiet(input string tag);
    int c;
    c = 0;
    repeat (2000) begin
      @(negedge clk);
      c += frac_en + samp_en + baud_tick;
    end
    chk_eq(tag, c, 0);
  endtask

  task automatic t_idle;
    dl_value = 16'd2;
    reg_write(A_PS, 2);
    reg_write(A_MUL, 3);
    reg_write(A_DIV, 0);
    count_quiet("R6 DIV zero quiet");
    reg_write(A_DIV, 9);
    reg_write(A_MUL, 10);
    count_quiet("R6 MUL above DIV quiet");
    reg_write(A_MUL, 5);
    reg_write(A_PS, 0);
    count_quiet("R7 PS zero quiet");
    reg_write(A_PS, 2);
    dl_value = 16'd0;
    count_quiet("R7 DL zero quiet");
  endtask

  task automatic t_restart;
    dl_value = 16'd4;
    reg_write(A_MUL, 1);
    reg_write(A_DIV, 1);
    reg_write(A_PS, 1);
    repeat (7) @(negedge clk);
    // write edge lies between this negedge and the next
    @(negedge clk);
    wr_en = 1'b1; addr = A_PS; wdata = 32'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk_eq("R8 frac cleared", frac_en, 0);
    chk_eq("R8 samp cleared", samp_en, 0);
    chk_eq("R8 tick cleared", baud_tick, 0);
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      if (n == 1) begin
        chk_eq("R8 frac one cycle after", frac_en, 1);
        chk_eq("R8 samp not yet", samp_en, 0);
      end
      if (n == 2) chk_eq("R8 samp two cycles after", samp_en, 1);
      chk_eq($sformatf("R8 tick at cycle %0d", n), baud_tick,
             (n == 6 || n == 10 || n == 14) ? 1 : 0);
    end
  endtask

  task automatic t_dl_change;
    repeat (3) @(negedge clk);
    dl_value = 16'd5;
    @(negedge clk);
    chk_eq("R9 outputs cleared", frac_en + samp_en + baud_tick, 0);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      chk_eq($sformatf("R9 tick at cycle %0d", n), baud_tick,
             (n == 7 || n == 12) ? 1 : 0);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; dl_value = 16'd16;
    repeat (3) @(negedge clk);
    t_reset;
    t_map;
    t_rate(96, 125, 16, 16, 100000);
    t_rate(3, 7, 2, 3, 14000);
    t_rate(5, 8, 1, 1, 8000);
    t_idle;
    t_restart;
    t_dl_change;
    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule